// File: doc/BRIEF.md
# Dual Winding Current Chopper

This block sits between a stepper-motor step translator and the power stages of two windings. For each winding pair it takes the unchopped phase levels and the inhibit level from the translator. A periodic chop tick arms a per-pair hold latch. A digital over-current flag from that pair's comparator clears the latch. While the latch is clear the block switches the pair's drive off, using one of two methods. In fast-decay mode it pulls the pair's inhibit low. In slow-decay mode it raises the idle phase line, so both lines of the pair are high and the winding current recirculates without passing the sense resistor.

The chop tick comes from one of two sources. The first is an internal divider with a programmable period. That tick is also sent out as a one-clock active-low sync pulse, so other controllers can share it. The second is a falling edge on an external sync input, which is used when the internal source is switched off. The block also drives a reference-select line. This line tells the external comparator reference to drop to about 70.7 % while both windings are energised, and to use the full level otherwise. This evens out torque between single-winding and dual-winding steps.

Top module: `dual_chopper`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `ph_out` and `inh_out` are all zero, `sync_out_n` is 1 and `ref_reduced` is 0.
- R2: A chop tick sets the hold latch of every pair. Each latch that is set lets its pair drive the translator levels unchanged, and its inhibit follows `inh_raw`.
- R3: A trip on `sense_trip[p]` clears only pair p's latch. That pair stays chopped until the next chop tick.
- R4: When a trip and a chop tick fall in the same cycle, the trip wins and the latch ends up clear.
- R5: With `ctrl_slow` = 0, a clear latch drives `inh_out[p]` low, and the pair's phase lines follow the translator.
- R6: With `ctrl_slow` = 1, a clear latch drives both phase lines of the pair high (`ph_out[2p+1:2p]` = 2'b11), and `inh_out[p]` follows the translator.
- R7: If `inh_raw[p]` is 0, then `inh_out[p]` is 0 in the next cycle, whatever the latch state.
- R8: If `enable` is 0, then all of `ph_out` and `inh_out` are 0 in the next cycle.
- R9: With `osc_int_en` = 1, the internal tick fires once every DIV_PERIOD clocks. `sync_out_n` shows each tick as a low pulse exactly one clock wide.
- R10: With `osc_int_en` = 0, the internal divider has no effect and `sync_out_n` stays 1. A 1-to-0 edge on `sync_in_n` gives one chop tick after SYNC_STAGES+1 clocks. The latches are set one clock after that tick, and the outputs follow one clock later.
- R11: `ref_reduced` is 1 one cycle after both `inh_raw` bits are 1 (two windings energised), and 0 otherwise.
- R12: Phase and inhibit outputs are registered. A translator change shows one clock later. Pair p drives bits 2p (first line) and 2p+1 (second line) of `ph_out`, so pair 0 is lines A,B and pair 1 is lines C,D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| ph_raw | input | 2*PAIRS | unchopped phase levels from the translator |
| inh_raw | input | PAIRS | unchopped inhibit levels (1 = pair energised) |
| sense_trip | input | PAIRS | per-pair over-current flag, 1 = above reference |
| ctrl_slow | input | 1 | 1 = chop the idle phase line, 0 = chop the inhibit |
| enable | input | 1 | 0 forces all phase and inhibit outputs low |
| osc_int_en | input | 1 | 1 = internal divider ticks, 0 = external sync ticks |
| sync_in_n | input | 1 | external active-low sync pulses |
| sync_out_n | output | 1 | internal tick as an active-low one-clock pulse |
| ph_out | output | 2*PAIRS | chopped phase lines |
| inh_out | output | PAIRS | chopped inhibit lines |
| ref_reduced | output | 1 | 1 = comparator reference at reduced level |

## Verification
An over-current trip and a chop tick can fall in the same cycle. The outcome then decides whether a winding that is already over current gets one more chop period of drive. The bench provokes this case by watching `sync_out_n`. On the falling half-cycle where the tick pulse is visible, it raises the trip of one pair only. Two clocks later it expects that pair's inhibit low and the other pair's inhibit high. The inhibit must stay low until the following tick. Elsewhere, a behavioural model running alongside the block applies randomised trips in both decay modes, through translator patterns and the enable and sync-source switches, and is compared on every clock.

// File: rtl/chop_pkg.sv
package chop_pkg;

  // Drive levels for one winding pair: two phase lines and an inhibit.
  typedef struct packed {
    logic [1:0] ph;
    logic       inh;
  } pair_drv_t;

  localparam pair_drv_t DRV_OFF = '{ph: 2'b00, inh: 1'b0};

  // Final drive of a pair from translator levels, mode and hold latch.
  function automatic pair_drv_t pair_drive(input logic en, input logic slow,
                                           input logic held,
                                           input logic [1:0] ph,
                                           input logic inh);
    pair_drv_t r;
    if (!en) begin
      r = DRV_OFF;
    end else if (slow) begin
      r.ph  = ph | {2{~held}};
      r.inh = inh;
    end else begin
      r.ph  = ph;
      r.inh = inh & held;
    end
    return r;
  endfunction

endpackage

// File: rtl/chop_tick_gen.sv
module chop_tick_gen #(
  parameter int DIV_PERIOD  = 1667,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_int_en,
  input  logic sync_in_n,
  output logic tick,
  output logic sync_out_n
);

  localparam int CW = (DIV_PERIOD > 2) ? $clog2(DIV_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_PERIOD - 1);

  logic [CW-1:0]        cnt;
  logic                 tick_int_q;
  logic                 tick_ext_q;
  logic [SYNC_STAGES:0] ext_sh;
  logic                 wrap;

  assign wrap = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      tick_int_q <= 1'b0;
      sync_out_n <= 1'b1;
    end else begin
      cnt        <= wrap ? '0 : cnt + 1'b1;
      tick_int_q <= osc_int_en & wrap;
      sync_out_n <= ~(osc_int_en & wrap);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_sh     <= '1;
      tick_ext_q <= 1'b0;
    end else begin
      ext_sh     <= {ext_sh[SYNC_STAGES-1:0], sync_in_n};
      tick_ext_q <= ~osc_int_en & ext_sh[SYNC_STAGES] & ~ext_sh[SYNC_STAGES-1];
    end
  end

  assign tick = osc_int_en ? tick_int_q : tick_ext_q;

  // R9
  sync_one_wide_chk: assert property (@(posedge clk) disable iff (rst)
    !sync_out_n |=> sync_out_n);

  // R10
  ext_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !osc_int_en |=> sync_out_n);

endmodule

// File: rtl/chop_pair.sv
module chop_pair
  import chop_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       trip,
  input  logic       enable,
  input  logic       ctrl_slow,
  input  logic [1:0] ph_raw,
  input  logic       inh_raw,
  output logic [1:0] ph_out,
  output logic       inh_out
);

  logic      held;
  pair_drv_t drv_d, drv_q;

  // Trip outranks the tick so an over-current pair never gets re-armed.
  always_ff @(posedge clk) begin
    if (rst)       held <= 1'b0;
    else if (trip) held <= 1'b0;
    else if (tick) held <= 1'b1;
  end

  assign drv_d = pair_drive(enable, ctrl_slow, held, ph_raw, inh_raw);

  always_ff @(posedge clk) begin
    if (rst) drv_q <= DRV_OFF;
    else     drv_q <= drv_d;
  end

  assign ph_out  = drv_q.ph;
  assign inh_out = drv_q.inh;

  // R2
  tick_sets_chk: assert property (@(posedge clk) disable iff (rst)
    tick && !trip |=> held);

  // R3 R4
  trip_clears_chk: assert property (@(posedge clk) disable iff (rst)
    trip |=> !held);

  // R3
  no_self_set_chk: assert property (@(posedge clk) disable iff (rst)
    !held && !tick |=> !held);

  // R5
  fast_chop_chk: assert property (@(posedge clk) disable iff (rst)
    enable && !ctrl_slow && !held |=> !inh_out);

  // R6
  slow_chop_chk: assert property (@(posedge clk) disable iff (rst)
    enable && ctrl_slow && !held |=> ph_out == 2'b11);

  // R7
  inh_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !inh_raw |=> !inh_out);

  // R8
  enable_off_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (ph_out == 2'b00) && !inh_out);

endmodule

// File: rtl/dual_chopper.sv
module dual_chopper #(
  parameter int PAIRS       = 2,
  parameter int DIV_PERIOD  = 1667,  // about 30 kHz from a 50 MHz clock
  parameter int SYNC_STAGES = 2,
  parameter bit TORQUE_COMP = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2*PAIRS-1:0] ph_raw,
  input  logic [PAIRS-1:0]   inh_raw,
  input  logic [PAIRS-1:0]   sense_trip,
  input  logic               ctrl_slow,
  input  logic               enable,
  input  logic               osc_int_en,
  input  logic               sync_in_n,
  output logic               sync_out_n,
  output logic [2*PAIRS-1:0] ph_out,
  output logic [PAIRS-1:0]   inh_out,
  output logic               ref_reduced
);

  logic tick;

  chop_tick_gen #(
    .DIV_PERIOD (DIV_PERIOD),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_tick (
    .clk       (clk),
    .rst       (rst),
    .osc_int_en(osc_int_en),
    .sync_in_n (sync_in_n),
    .tick      (tick),
    .sync_out_n(sync_out_n)
  );

  for (genvar g = 0; g < PAIRS; g++) begin : g_pair
    chop_pair u_pair (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick),
      .trip     (sense_trip[g]),
      .enable   (enable),
      .ctrl_slow(ctrl_slow),
      .ph_raw   (ph_raw[2*g+1:2*g]),
      .inh_raw  (inh_raw[g]),
      .ph_out   (ph_out[2*g+1:2*g]),
      .inh_out  (inh_out[g])
    );
  end

  // All windings energised means a multi-phase-on step: lower the reference.
  always_ff @(posedge clk) begin
    if (rst) ref_reduced <= 1'b0;
    else     ref_reduced <= TORQUE_COMP & (&inh_raw);
  end

  // R11
  ref_single_chk: assert property (@(posedge clk) disable iff (rst)
    !(&inh_raw) |=> !ref_reduced);

endmodule

// File: tb/sim_dual_chopper.sv
module sim_dual_chopper;

  localparam int CLK_PERIOD = 10;
  localparam int DIV = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] ph_raw = 4'b1010;
  logic [1:0] inh_raw = 2'b11;
  logic [1:0] sense_trip = 2'b00;
  logic ctrl_slow = 1'b0, enable = 1'b1, osc_int_en = 1'b1, sync_in_n = 1'b1;
  logic sync_out_n, ref_reduced;
  logic [3:0] ph_out;
  logic [1:0] inh_out;

  int checks = 0, failures = 0;
  int cyc = 0;
  bit rand_trips = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_chopper #(.PAIRS(2), .DIV_PERIOD(DIV), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .ph_raw(ph_raw), .inh_raw(inh_raw),
    .sense_trip(sense_trip), .ctrl_slow(ctrl_slow), .enable(enable),
    .osc_int_en(osc_int_en), .sync_in_n(sync_in_n), .sync_out_n(sync_out_n),
    .ph_out(ph_out), .inh_out(inh_out), .ref_reduced(ref_reduced));

  // Behavioural model
  int m_cnt = 0;
  bit m_ti = 0, m_te = 0, m_so = 1, m_ref = 0, m_valid = 0, m_tk = 0;
  bit [2:0] m_sh = 3'b111;
  bit [1:0] m_lat = 0, m_nl = 0, m_inh = 0;
  bit [3:0] m_ph = 0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_cnt = 0; m_ti = 0; m_te = 0; m_so = 1; m_ref = 0;
      m_sh = 3'b111; m_lat = 0; m_ph = 0; m_inh = 0; m_valid = 1;
    end else begin
      m_tk = osc_int_en ? m_ti : m_te;
      for (int p = 0; p < 2; p++) begin
        m_nl[p] = sense_trip[p] ? 1'b0 : (m_tk ? 1'b1 : m_lat[p]);
        if (!enable) begin
          m_ph[2*p +: 2] = 2'b00; m_inh[p] = 1'b0;
        end else if (ctrl_slow) begin
          m_ph[2*p +: 2] = m_lat[p] ? ph_raw[2*p +: 2] : 2'b11;
          m_inh[p] = inh_raw[p];
        end else begin
          m_ph[2*p +: 2] = ph_raw[2*p +: 2];
          m_inh[p] = inh_raw[p] && m_lat[p];
        end
      end
      m_lat = m_nl;
      m_ref = inh_raw[0] && inh_raw[1];
      m_te = !osc_int_en && m_sh[2] && !m_sh[1];
      m_sh = {m_sh[1:0], sync_in_n};
      m_ti = osc_int_en && (m_cnt == DIV-1);
      m_so = !m_ti;
      m_cnt = (m_cnt == DIV-1) ? 0 : m_cnt + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (m_valid && !done) begin
      chk("R2 R6 R8 R12", "ph_out", ph_out, m_ph);
      chk("R5 R7 R8", "inh_out", inh_out, m_inh);
      chk("R9 R10", "sync_out_n", sync_out_n, m_so);
      chk("R11", "ref_reduced", ref_reduced, m_ref);
    end
  end

  // Random trips driven on falling edges
  always @(negedge clk) begin
    if (rand_trips) sense_trip <= 2'($urandom_range(0, 3) & $urandom_range(0, 3) & $urandom_range(0, 3));
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_tick();
    while (sync_out_n !== 1'b0) @(negedge clk);
  endtask

  initial begin
    int t0, t1;
    cycles(3);
    // R1
    chk("R1", "ph_out in reset", ph_out, 0);
    chk("R1", "inh_out in reset", inh_out, 0);
    chk("R1", "sync_out_n in reset", sync_out_n, 1);
    chk("R1", "ref_reduced in reset", ref_reduced, 0);
    rst = 1'b0;

    // R2: first tick arms both pairs
    wait_tick();
    cycles(2);
    chk("R2", "inh_out after tick", inh_out, 2'b11);
    chk("R12", "ph_out order", ph_out, 4'b1010);

    // R9: tick interval
    wait_tick(); t0 = cyc;
    @(negedge clk);
    chk("R9", "sync pulse width", sync_out_n, 1);
    wait_tick(); t1 = cyc;
    chk("R9", "tick interval", t1 - t0, DIV);

    // R4 and R3: trip in the tick cycle on pair 0 only
    @(negedge clk);
    wait_tick();
    sense_trip = 2'b01;
    @(negedge clk);
    sense_trip = 2'b00;
    @(negedge clk);
    chk("R4", "inh_out trip wins", inh_out, 2'b10);
    cycles(10);
    chk("R3", "pair0 stays off", inh_out, 2'b10);
    wait_tick();
    cycles(2);
    chk("R3", "rearmed by next tick", inh_out, 2'b11);

    // R11: one winding off, then both on
    inh_raw = 2'b01; @(negedge clk);
    chk("R11", "ref single", ref_reduced, 0);
    chk("R7", "inh low from translator", inh_out[1], 0);
    inh_raw = 2'b11; @(negedge clk);
    chk("R11", "ref dual", ref_reduced, 1);

    // Fast mode random trips across half-step patterns
    rand_trips = 1;
    for (int s = 0; s < 8; s++) begin
      case (s)
        0: begin ph_raw = 4'b1010; inh_raw = 2'b11; end
        1: begin ph_raw = 4'b1000; inh_raw = 2'b10; end
        2: begin ph_raw = 4'b1001; inh_raw = 2'b11; end
        3: begin ph_raw = 4'b0001; inh_raw = 2'b01; end
        4: begin ph_raw = 4'b0101; inh_raw = 2'b11; end
        5: begin ph_raw = 4'b0100; inh_raw = 2'b10; end
        6: begin ph_raw = 4'b0110; inh_raw = 2'b11; end
        default: begin ph_raw = 4'b0010; inh_raw = 2'b01; end
      endcase
      cycles(45);
    end

    // R6: slow mode with trips
    ctrl_slow = 1'b1;
    for (int s = 0; s < 4; s++) begin
      ph_raw = (s[0]) ? 4'b0110 : 4'b1001;
      inh_raw = 2'b11;
      cycles(60);
    end
    rand_trips = 0; sense_trip = 2'b00;
    @(negedge clk);
    wait_tick();
    sense_trip = 2'b10;
    @(negedge clk);
    sense_trip = 2'b00;
    @(negedge clk);
    chk("R6", "slow chop pair1 both high", ph_out[3:2], 2'b11);
    chk("R6", "slow chop inhibit kept", inh_out, 2'b11);

    // R8: enable low
    enable = 1'b0; rand_trips = 1;
    cycles(2);
    chk("R8", "ph_out disabled", ph_out, 0);
    chk("R8", "inh_out disabled", inh_out, 0);
    cycles(30);
    enable = 1'b1; ctrl_slow = 1'b0;
    cycles(40);
    rand_trips = 0; sense_trip = 2'b00;

    // R10: external sync
    osc_int_en = 1'b0;
    cycles(3);
    sense_trip = 2'b11; @(negedge clk); sense_trip = 2'b00;
    cycles(2 * DIV);
    chk("R10", "internal ticks ignored", inh_out, 2'b00);
    chk("R10", "sync_out_n idle", sync_out_n, 1);
    sync_in_n = 1'b0;
    cycles(4);
    chk("R10", "before ext tick lands", inh_out, 2'b00);
    @(negedge clk);
    chk("R10", "ext tick arms pairs", inh_out, 2'b11);
    sync_in_n = 1'b1;
    rand_trips = 1;
    for (int k = 0; k < 6; k++) begin
      cycles(7); sync_in_n = 1'b0; cycles(3); sync_in_n = 1'b1;
    end
    rand_trips = 0; sense_trip = 2'b00;
    osc_int_en = 1'b1;
    cycles(50);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule